// File: doc/BRIEF.md
# JTAG Test Port with SPI Flash Pass-Through

This block is a JTAG test access port whose data-register path can be turned into a direct link to an external SPI flash. A host loads a designated user instruction and then moves to SHIFT-DR. From that point every TCK cycle is also one SPI clock cycle. The serial data input goes straight out as the flash's serial input, and the flash's serial output comes back on TDO. The flash chip select is active only while the port stays in SHIFT-DR with the user instruction loaded. One uninterrupted SHIFT-DR pass therefore forms exactly one flash command.

The flash output is registered on the rising TCK edge and launched on TDO at the falling edge. This costs one bit of latency: the host sends one more bit than it needs and drops the leading bit of every read. Outside the bridge instruction the port behaves as a plain TAP. It has the 16-state controller, a 6-bit instruction register, a 32-bit identification register and a one-bit bypass register.

Top module: `jspi_bridge_tap`

## Requirements
- R1: An asynchronous low level on `trstN` puts the controller in test-logic-reset. In that state `spiCsN` is 1, `tdo` is 0, and the instruction register holds the identification opcode 6'h01.
- R2: Five consecutive rising TCK edges with `tms` high reach test-logic-reset from any state, and the instruction register is reloaded with 6'h01.
- R3: In CAPTURE-IR the instruction shift register loads 6'b000001. Shifting it out LSB first therefore yields 1,0,0,0,0,0.
- R4: With opcode 6'h01 a data scan returns the 32-bit identification constant LSB first, and its bit 0 is always 1.
- R5: Opcode 6'h3F, and any opcode other than 6'h01 and 6'h02, selects a one-bit bypass register. It captures 0, so `tdo` shows 0 first and then repeats `tdi` delayed by one bit.
- R6: `spiCsN` is 0 only while the controller is in SHIFT-DR and the instruction register holds 6'h02. It is 1 in every other state or instruction, including SHIFT-IR and the states after leaving SHIFT-DR.
- R7: `spiSck` equals `tck` and `spiMosi` equals `tdi` at all times.
- R8: During a bridge scan, `spiMiso` is sampled on each rising TCK edge and appears on `tdo` at the next falling edge. The first bit read therefore holds the value sampled on the edge that entered SHIFT-DR, and read bit k holds the flash bit driven for edge k-1.
- R9: `tdo` changes only on falling TCK edges and is 0 whenever the controller is in neither SHIFT-IR nor SHIFT-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock, also forwarded as the SPI clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in, also forwarded as SPI serial data out |
| tdo | output | 1 | Test data out, launched on falling TCK |
| spiSck | output | 1 | SPI clock to the flash |
| spiMosi | output | 1 | SPI serial data to the flash |
| spiCsN | output | 1 | SPI chip select, active low |
| spiMiso | input | 1 | SPI serial data from the flash |

## Verification
On the rising edge that leaves SHIFT-DR, the flash's final bit is captured into the retiming flop while chip select returns high. That bit therefore never reaches `tdo`. The bench provokes this at the end of every bridge scan. It drives a known flash pattern with the exit requested on the last bit, checks that every read bit equals the flash bit of the previous edge, and checks that `spiCsN` is already high right after the exit edge. A second pairing is an update of the instruction register followed directly by a sweep into test-logic-reset. The bench shifts a non-identification opcode into the register while holding `tms` high for five edges, then confirms that the identification constant comes back.

// File: rtl/jspi_pkg.sv
`timescale 1ns/1ps
package jspi_pkg;

  typedef enum logic [3:0] {
    ST_RESET,  ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  // strobes from control to datapath, all decoded from the current state
  typedef struct packed {
    logic inReset;
    logic capIr;
    logic shIr;
    logic updIr;
    logic capDr;
    logic shDr;
  } tapStrobe_t;

  function automatic tapState_e tapNext(input tapState_e cur, input logic m);
    tapState_e nxt;
    case (cur)
      ST_RESET:  nxt = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = m ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/jspi_tap_ctrl.sv
`timescale 1ns/1ps
module jspi_tap_ctrl
  import jspi_pkg::*;
#(
  parameter int RESET_RUN = 5
) (
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapStrobe_t strb
);

  localparam int RUN_W = $clog2(RESET_RUN + 1);

  tapState_e stateQ;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) stateQ <= ST_RESET;
    else        stateQ <= tapNext(stateQ, tms);
  end

  always_comb begin
    strb.inReset = (stateQ == ST_RESET);
    strb.capIr   = (stateQ == ST_CAP_IR);
    strb.shIr    = (stateQ == ST_SH_IR);
    strb.updIr   = (stateQ == ST_UPD_IR);
    strb.capDr   = (stateQ == ST_CAP_DR);
    strb.shDr    = (stateQ == ST_SH_DR);
  end

  // independent count of consecutive high tms samples, used only to check R2
  logic [RUN_W-1:0] tmsRun;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                      tmsRun <= '0;
    else if (!tms)                   tmsRun <= '0;
    else if (tmsRun != RUN_W'(RESET_RUN)) tmsRun <= tmsRun + 1'b1;
  end

  p_five_high_reset_r2: assert property (@(posedge tck) disable iff (!trstN)
    (tmsRun == RUN_W'(RESET_RUN)) |-> (stateQ == ST_RESET));

  // R6: a bridge transaction stays open while tms is low in SHIFT-DR
  p_shift_dr_hold_r6: assert property (@(posedge tck) disable iff (!trstN)
    (stateQ == ST_SH_DR && !tms) |=> (stateQ == ST_SH_DR));

endmodule

// File: rtl/jspi_tap_datapath.sv
`timescale 1ns/1ps
module jspi_tap_datapath
  import jspi_pkg::*;
#(
  parameter int                   IR_WIDTH     = 6,
  parameter int                   ID_WIDTH     = 32,
  parameter logic [ID_WIDTH-1:0]  IDCODE_VALUE = 32'h4B7A_1C2F,
  parameter logic [IR_WIDTH-1:0]  USER_OP      = 6'h02,
  parameter logic [IR_WIDTH-1:0]  IDCODE_OP    = 6'h01
) (
  input  logic       tck,
  input  logic       trstN,
  input  logic       tdi,
  input  logic       spiMiso,
  input  tapStrobe_t strb,
  output logic       tdo,
  output logic       spiCsN
);

  localparam logic [IR_WIDTH-1:0] IR_CAPTURE = {{(IR_WIDTH-2){1'b0}}, 2'b01};
  localparam logic [ID_WIDTH-1:0] ID_CONST   = {IDCODE_VALUE[ID_WIDTH-1:1], 1'b1};

  logic [IR_WIDTH-1:0] irShift;
  logic [IR_WIDTH-1:0] irQ;
  logic [ID_WIDTH-1:0] idShift;
  logic                bypassQ;
  logic                misoQ;
  logic                tdoQ;
  logic                tdoNext;
  logic                selUser;
  logic                selIdcode;

  // instruction shift stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)          irShift <= IR_CAPTURE;
    else if (strb.capIr) irShift <= IR_CAPTURE;
    else if (strb.shIr)  irShift <= {tdi, irShift[IR_WIDTH-1:1]};
  end

  // instruction hold stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            irQ <= IDCODE_OP;
    else if (strb.inReset) irQ <= IDCODE_OP;
    else if (strb.updIr)   irQ <= irShift;
  end

  assign selUser   = (irQ == USER_OP);
  assign selIdcode = (irQ == IDCODE_OP);

  // identification register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                       idShift <= ID_CONST;
    else if (strb.capDr && selIdcode) idShift <= ID_CONST;
    else if (strb.shDr && selIdcode)  idShift <= {tdi, idShift[ID_WIDTH-1:1]};
  end

  // bypass register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)          bypassQ <= 1'b0;
    else if (strb.capDr) bypassQ <= 1'b0;
    else if (strb.shDr)  bypassQ <= tdi;
  end

  // flash output retiming: rising-edge capture
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) misoQ <= 1'b0;
    else        misoQ <= spiMiso;
  end

  always_comb begin
    if (strb.shIr)        tdoNext = irShift[0];
    else if (strb.shDr) begin
      if (selUser)        tdoNext = misoQ;
      else if (selIdcode) tdoNext = idShift[0];
      else                tdoNext = bypassQ;
    end
    else                  tdoNext = 1'b0;
  end

  // falling-edge launch
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) tdoQ <= 1'b0;
    else        tdoQ <= tdoNext;
  end

  assign tdo    = tdoQ;
  assign spiCsN = ~(strb.shDr & selUser);

  p_ir_reset_load_r1: assert property (@(posedge tck) disable iff (!trstN)
    strb.inReset |=> (irQ == IDCODE_OP));

  p_ir_capture_r3: assert property (@(posedge tck) disable iff (!trstN)
    strb.capIr |=> (irShift[1:0] == 2'b01));

  p_bypass_zero_r5: assert property (@(posedge tck) disable iff (!trstN)
    (strb.capDr && !selUser && !selIdcode) |=> (bypassQ == 1'b0));

  p_ir_stable_cs_r6: assert property (@(posedge tck) disable iff (!trstN)
    (!spiCsN && $past(!spiCsN)) |-> $stable(irQ));

endmodule

// File: rtl/jspi_bridge_tap.sv
`timescale 1ns/1ps
module jspi_bridge_tap
  import jspi_pkg::*;
#(
  parameter int                   IR_WIDTH     = 6,
  parameter int                   ID_WIDTH     = 32,
  parameter logic [ID_WIDTH-1:0]  IDCODE_VALUE = 32'h4B7A_1C2F,
  parameter logic [IR_WIDTH-1:0]  USER_OP      = 6'h02,
  parameter logic [IR_WIDTH-1:0]  IDCODE_OP    = 6'h01
) (
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic spiSck,
  output logic spiMosi,
  output logic spiCsN,
  input  logic spiMiso
);

  tapStrobe_t strb;

  jspi_tap_ctrl #(.RESET_RUN(5)) uCtrl (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .strb  (strb)
  );

  jspi_tap_datapath #(
    .IR_WIDTH     (IR_WIDTH),
    .ID_WIDTH     (ID_WIDTH),
    .IDCODE_VALUE (IDCODE_VALUE),
    .USER_OP      (USER_OP),
    .IDCODE_OP    (IDCODE_OP)
  ) uData (
    .tck     (tck),
    .trstN   (trstN),
    .tdi     (tdi),
    .spiMiso (spiMiso),
    .strb    (strb),
    .tdo     (tdo),
    .spiCsN  (spiCsN)
  );

  // the flash sees the test clock and test data unchanged
  assign spiSck  = tck;
  assign spiMosi = tdi;

endmodule

// File: tb/tb_jspi_bridge_tap.sv
`timescale 1ns/1ps
module tb_jspi_bridge_tap;

  localparam int          TCK_PERIOD = 20;
  localparam logic [31:0] ID_EXPECT  = 32'h4B7A_1C2F;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic spiMiso = 1'b1;
  logic tdo, spiSck, spiMosi, spiCsN;

  int totalCount = 0;
  int passCount  = 0;
  int failCount  = 0;
  bit done = 1'b0;

  logic  expQ[$];
  logic  actQ[$];
  string tagQ[$];
  event  sampleEv;

  jspi_bridge_tap #(.IDCODE_VALUE(ID_EXPECT)) dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo),
    .spiSck(spiSck), .spiMosi(spiMosi), .spiCsN(spiCsN), .spiMiso(spiMiso)
  );

  initial forever #(TCK_PERIOD/2) tck = ~tck;

  // driver side: push expected and observed items
  task automatic expectBit(input logic act, input logic exp, input string tag);
    expQ.push_back(exp);
    actQ.push_back(act);
    tagQ.push_back(tag);
    ->sampleEv;
  endtask

  // monitor: pops and compares
  initial forever begin
    @(sampleEv);
    while (expQ.size() > 0) begin
      logic e, a;
      string t;
      e = expQ.pop_front();
      a = actQ.pop_front();
      t = tagQ.pop_front();
      totalCount++;
      if (a === e) passCount++;
      else begin
        failCount++;
        $display("FAIL %s: actual %b expected %b", t, a, e);
      end
    end
  end

  task automatic step(input logic m, input logic d, input logic mi,
                      input logic chk, input logic expCs, output logic o);
    @(negedge tck);
    #1;
    o = tdo;
    tms = m; tdi = d; spiMiso = mi;
    if (chk) begin
      #1;
      expectBit(spiCsN, expCs, "R6 chip select gating");
      expectBit(spiMosi, d, "R7 mosi follows tdi");
    end
    @(posedge tck);
    #1;
  endtask

  task automatic scanIr(input logic [5:0] code, output logic [5:0] outBits);
    logic o;
    step(1, 0, 1, 0, 1, o);
    step(1, 0, 1, 0, 1, o);
    step(0, 0, 1, 0, 1, o);
    step(0, 0, 1, 0, 1, o);
    for (int j = 0; j < 6; j++) begin
      step(j == 5, code[j], 1, 1, 1, o);
      outBits[j] = o;
    end
    step(1, 0, 1, 0, 1, o);
    step(0, 0, 1, 0, 1, o);
  endtask

  task automatic scanDr(input int n, input logic [63:0] din, input logic [63:0] misoBits,
                        input logic bridge, output logic [63:0] dout);
    logic o;
    dout = '0;
    step(1, 0, 1, 0, 1, o);
    step(0, 0, 1, 0, 1, o);
    step(0, 0, 1, 0, 1, o);
    for (int j = 0; j < n; j++) begin
      step(j == n - 1, din[j], misoBits[j], 1, !bridge, o);
      dout[j] = o;
    end
    expectBit(spiCsN, 1'b1, "R6 chip select high after leaving SHIFT-DR");
    step(1, 0, 1, 0, 1, o);
    expectBit(o, 1'b0, "R9 tdo idle in EXIT1-DR");
    step(0, 0, 1, 0, 1, o);
  endtask

  task automatic checkIdcode(input string tag);
    logic [63:0] dout;
    scanDr(32, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 0, dout);
    for (int j = 0; j < 32; j++) expectBit(dout[j], ID_EXPECT[j], tag);
    expectBit(dout[0], 1'b1, "R4 idcode bit 0 set");
  endtask

  task automatic checkBypass(input logic [7:0] pat, input string tag);
    logic [63:0] dout;
    scanDr(8, {56'h0, pat}, 64'hFFFF_FFFF_FFFF_FFFF, 0, dout);
    expectBit(dout[0], 1'b0, tag);
    for (int j = 1; j < 8; j++) expectBit(dout[j], pat[j-1], tag);
  endtask

  initial begin
    logic [5:0]  irOut;
    logic [63:0] dout;
    logic        o;
    logic [15:0] mosiPat;
    logic [15:0] misoPat;

    // R1: reset state
    #(TCK_PERIOD * 3 + 3);
    expectBit(spiCsN, 1'b1, "R1 chip select high in reset");
    expectBit(tdo, 1'b0, "R1 tdo low in reset");
    @(negedge tck);
    trstN = 1'b1;
    step(0, 0, 1, 0, 1, o);

    // R1, R4: identification selected after reset
    checkIdcode("R1 R4 idcode after reset");

    // R3 and R5: bypass opcode
    scanIr(6'h3F, irOut);
    expectBit(irOut[0], 1'b1, "R3 ir capture bit0");
    expectBit(irOut[1], 1'b0, "R3 ir capture bit1");
    for (int j = 2; j < 6; j++) expectBit(irOut[j], 1'b0, "R3 ir capture upper");
    checkBypass(8'b1011_0010, "R5 bypass opcode");

    // R5: unassigned opcode behaves as bypass
    scanIr(6'h15, irOut);
    checkBypass(8'h6C, "R5 unassigned opcode bypass");

    // R2: five tms-high edges from SHIFT-IR, with an update on the way
    step(1, 0, 1, 0, 1, o);
    step(1, 0, 1, 0, 1, o);
    step(0, 0, 1, 0, 1, o);
    step(0, 0, 1, 0, 1, o);
    for (int j = 0; j < 5; j++) step(1, 1, 1, 0, 1, o);
    step(0, 0, 1, 0, 1, o);
    checkIdcode("R2 idcode after tms reset");

    // R6, R7, R8: bridge scan
    scanIr(6'h02, irOut);
    expectBit(spiCsN, 1'b1, "R6 chip select high in RUN-TEST/IDLE");
    mosiPat = 16'hC3A5;
    misoPat = 16'h5E91;
    scanDr(16, {48'h0, mosiPat}, {48'h0, misoPat}, 1, dout);
    expectBit(dout[0], 1'b1, "R8 stale leading bit");
    for (int j = 1; j < 16; j++) expectBit(dout[j], misoPat[j-1], "R8 miso one bit late");

    // R7: clock forwarding at both levels
    @(posedge tck); #1;
    expectBit(spiSck, 1'b1, "R7 sck high");
    @(negedge tck); #1;
    expectBit(spiSck, 1'b0, "R7 sck low");

    // R6: SHIFT-IR with bridge loaded keeps select high (checked inside scanIr)
    scanIr(6'h3F, irOut);
    expectBit(irOut[0], 1'b1, "R3 ir capture with bridge loaded");

    // R1: asynchronous reset between edges
    @(posedge tck); #3;
    trstN = 1'b0;
    #2;
    expectBit(spiCsN, 1'b1, "R1 async reset chip select");
    expectBit(tdo, 1'b0, "R1 async reset tdo");
    trstN = 1'b1;
    step(0, 0, 1, 0, 1, o);
    checkIdcode("R1 idcode after async reset");

    #(TCK_PERIOD);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", passCount, totalCount);
      $finish;
    end
  end

  initial begin
    #(TCK_PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      totalCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", passCount, totalCount);
      $finish;
    end
  end

endmodule